// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial bus placed in front of a small byte-wide memory. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It compares the device byte against three strap inputs. A write transaction carries two memory address bytes and then data bytes. The data bytes are collected in a page buffer. The buffer is written into the array only when a stop follows directly after a data acknowledge and write protect is low. While that write runs, the block stays silent on the bus. A master learns that the write has finished by polling for an acknowledge.

A read transaction returns bytes from the internal address counter, which advances after each byte. To read a chosen location, the master first sends a write transaction that carries only the address bytes, then issues a repeated start with the read bit set. The data line is open drain: `sda_oe` high pulls the line low.

The controller is one state machine with these states:
- `S_OFF`: after reset, until power is good.
- `S_IDLE`: waiting for a start.
- `S_RX`: shifting in a byte. The sub-kind is device, high address, low address or data.
- `S_ACK`: driving an acknowledge.
- `S_TX`: shifting out a read byte.
- `S_MACK`: sampling the master's acknowledge.
- `S_SKIP`: released, waiting for a stop or start.
- `S_BUSY`: write cycle running.

The transitions are:
- `S_OFF`→`S_IDLE` on power good.
- Any bus state →`S_RX` on a start.
- `S_RX`→`S_ACK` on an accepted byte.
- `S_RX`→`S_SKIP` on an address mismatch.
- `S_ACK`→`S_RX` for a write, or `S_ACK`→`S_TX` for a read.
- `S_TX`→`S_MACK` after eight bits.
- `S_MACK`→`S_TX` on a master acknowledge, or `S_MACK`→`S_SKIP` on a master not-acknowledge.
- Stop →`S_BUSY` when a commit is due, otherwise →`S_IDLE`.
- `S_BUSY`→`S_IDLE` when the timer ends.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The device byte is bits 7..4 = 1010, bits 3..1 = strap inputs, bit 0 = read (1) or write (0). On a match the slave pulls SDA low during the ninth SCL clock.
- R2: When bits 3..1 differ from the straps, the slave gives no acknowledge and keeps SDA released until the next start.
- R3: After reset, the slave never drives SDA until `pwr_good` has been seen high.
- R4: In a write, the next two bytes are the memory address, high byte first. Address bits at or above ADDR_W are ignored.
- R5: Each write data byte is acknowledged and buffered at the current address. The low 6 address bits then advance and wrap within the 64-byte page, while the upper bits stay fixed.
- R6: Buffered data reaches the array only when a stop occurs in the SCL clock directly after a data-byte acknowledge. A stop at any other point discards the buffer and leaves the slave idle.
- R7: With `wp` high at that stop, nothing is written and the next transaction is acknowledged at once.
- R8: During the write cycle, the slave acknowledges nothing, including its own read or write address. After the cycle ends, a poll with R/W = 0 is acknowledged.
- R9: A read returns the byte at the address counter, most significant bit first. The counter then advances across the full address space and wraps from the top address to 0.
- R10: A master not-acknowledge ends the read. SDA stays released through the following stop.
- R11: Incoming bits are taken at SCL rising edges. The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-good indication that enables bus response |
| addr_strap | input | 3 | Device select straps compared with device byte bits 3..1 |
| wp | input | 1 | Write protect: high blocks the commit |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open drain) |

## Verification
The hardest condition to create from the ports is a stop that arrives in the clock directly after a data acknowledge, as opposed to one arriving a few data bits later. The bench's bit-level master produces both cases. It ends one transaction immediately after the acknowledge clock and cuts another off three bits into the next byte. It then probes the bus at once to tell a running write cycle from an idle slave. The busy window is probed by sending both read and write device bytes within a few hundred clocks of the stop. The bench then polls until an acknowledge returns.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_SKIP,
        S_BUSY
    } twi_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/twi_line_sense.sv
module twi_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    // SDA edges with SCL held high on both samples
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 400
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     buf_clear,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int BASE_W     = ADDR_W - PAGE_W;
    localparam int TW         = $clog2(WR_CYCLES + 1);
    localparam logic [TW-1:0] T_LAST = TW'(WR_CYCLES - 1);
    localparam logic [TW-1:0] T_PB   = TW'(PAGE_BYTES);
    localparam logic [TW-1:0] T_ONE  = TW'(1);

    logic [7:0]            page_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [7:0]            mem_q  [MEM_BYTES];
    logic [BASE_W-1:0]     base_q;
    logic [TW-1:0]         tmr_q;
    logic                  busy_q;
    logic [PAGE_W-1:0]     wr_idx;
    logic                  wr_en;
    logic                  cycle_end;

    assign wr_idx    = tmr_q[PAGE_W-1:0];
    assign wr_en     = busy_q && (tmr_q < T_PB) && vld_q[wr_idx];
    assign cycle_end = busy_q && (tmr_q == T_LAST);
    assign busy      = busy_q;

    always_ff @(posedge clk) begin
        if (buf_we) page_q[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            busy_q <= 1'b0;
            tmr_q  <= '0;
            base_q <= '0;
        end else begin
            if (buf_clear || cycle_end) vld_q <= '0;
            else if (buf_we)            vld_q[buf_idx] <= 1'b1;
            if (commit_go) begin
                busy_q <= 1'b1;
                tmr_q  <= '0;
                base_q <= page_base;
            end else if (busy_q) begin
                tmr_q <= tmr_q + T_ONE;
                if (cycle_end) busy_q <= 1'b0;
            end
        end
    end

    // one buffered byte per clock during the first PAGE_BYTES clocks of the cycle
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{base_q, wr_idx}] <= page_q[wr_idx];
    end

    always_ff @(posedge clk) begin
        rd_data <= mem_q[rd_addr];
    end

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_ee_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [2:0] addr_strap,
    input  logic       wp,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

    twi_state_t        state_q, state_d;
    rx_kind_t          kind_q, kind_d;
    logic [3:0]        bit_q, bit_d;
    logic [7:0]        sh_q, sh_d;
    logic [7:0]        tx_q, tx_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              rd_q, rd_d;
    logic              pend_q, pend_d;
    logic              arm_q, arm_d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic buf_we, buf_clear, commit_go, busy;
    logic [7:0] rd_data;

    twi_line_sense #(.SYNC_STAGES(2)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_page_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_we    (buf_we),
        .buf_idx   (addr_q[PAGE_W-1:0]),
        .buf_din   (sh_q),
        .buf_clear (buf_clear),
        .commit_go (commit_go),
        .page_base (addr_q[ADDR_W-1:PAGE_W]),
        .rd_addr   (addr_q),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    // next-state and control strobes
    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        bit_d     = bit_q;
        sh_d      = sh_q;
        tx_d      = tx_q;
        addr_d    = addr_q;
        rd_d      = rd_q;
        pend_d    = pend_q;
        arm_d     = arm_q;
        buf_we    = 1'b0;
        buf_clear = 1'b0;
        commit_go = 1'b0;
        unique case (state_q)
            S_OFF: begin
                if (pwr_good) state_d = S_IDLE;
            end
            S_BUSY: begin
                if (!busy) state_d = S_IDLE;
            end
            default: begin
                if (start_det) begin
                    state_d = S_RX;
                    kind_d  = K_DEV;
                    bit_d   = '0;
                    arm_d   = 1'b0;
                end else if (stop_det) begin
                    arm_d = 1'b0;
                    if (arm_q && !wp) begin
                        commit_go = 1'b1;
                        state_d   = S_BUSY;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else begin
                    unique case (state_q)
                        S_RX: begin
                            if (scl_rise) begin
                                sh_d  = {sh_q[6:0], sda_lvl};
                                bit_d = bit_q + 4'd1;
                            end
                            if (scl_fall) begin
                                arm_d = 1'b0;
                                if (bit_q == 4'd8) begin
                                    state_d = S_ACK;
                                    pend_d  = 1'b0;
                                    unique case (kind_q)
                                        K_DEV: begin
                                            if (sh_q[7:1] == {DEV_PREFIX, addr_strap}) begin
                                                rd_d      = sh_q[0];
                                                kind_d    = K_AHI;
                                                buf_clear = ~sh_q[0];
                                            end else begin
                                                state_d = S_SKIP;
                                            end
                                        end
                                        K_AHI: begin
                                            addr_d[ADDR_W-1:8] = sh_q[HI_W-1:0];
                                            kind_d = K_ALO;
                                        end
                                        K_ALO: begin
                                            addr_d[7:0] = sh_q;
                                            kind_d = K_DATA;
                                        end
                                        K_DATA: begin
                                            buf_we = 1'b1;
                                            pend_d = 1'b1;
                                            addr_d = {addr_q[ADDR_W-1:PAGE_W],
                                                      addr_q[PAGE_W-1:0] + P_ONE};
                                        end
                                    endcase
                                end
                            end
                        end
                        S_ACK: begin
                            if (scl_fall) begin
                                bit_d = '0;
                                if (rd_q) begin
                                    state_d = S_TX;
                                    tx_d    = rd_data;
                                    addr_d  = addr_q + A_ONE;
                                end else begin
                                    state_d = S_RX;
                                    arm_d   = pend_q;
                                end
                            end
                        end
                        S_TX: begin
                            if (scl_rise) bit_d = bit_q + 4'd1;
                            if (scl_fall) begin
                                if (bit_q == 4'd8) begin
                                    state_d = S_MACK;
                                    bit_d   = '0;
                                end else begin
                                    tx_d = {tx_q[6:0], 1'b0};
                                end
                            end
                        end
                        S_MACK: begin
                            if (scl_rise) sh_d = {sh_q[6:0], sda_lvl};
                            if (scl_fall) begin
                                if (!sh_q[0]) begin
                                    state_d = S_TX;
                                    tx_d    = rd_data;
                                    addr_d  = addr_q + A_ONE;
                                end else begin
                                    state_d = S_SKIP;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            kind_q  <= K_DEV;
            bit_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            pend_q  <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            tx_q    <= tx_d;
            addr_q  <= addr_d;
            rd_q    <= rd_d;
            pend_q  <= pend_d;
            arm_q   <= arm_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_ACK:   sda_oe = 1'b1;
            S_TX:    sda_oe = ~tx_q[7];
            default: sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic wp,
    input logic sda_oe,
    input logic scl_lvl,
    input logic stop_det,
    input logic busy
);
    logic pg_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pg_seen <= 1'b0;
        else if (pwr_good) pg_seen <= 1'b1;
    end

    a_r3_silent_before_power: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_seen |-> !sda_oe);

    a_r8_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r6_commit_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    a_r7_protect_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp));

    a_r11_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .wp       (wp),
    .sda_oe   (sda_oe),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .busy     (busy)
);

// File: tb/twi_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twi_eeprom_slave_bench;

    localparam int ADDR_W = 11;
    localparam int MASK   = (1 << ADDR_W) - 1;
    localparam int Q      = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic wp = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    quiet = 1'b0;
    string quiet_req = "R3";
    bit    done = 1'b0;

    logic [7:0] mem_m [int];
    logic [7:0] wdata [$];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    twi_eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_W(6), .WR_CYCLES(2000)) u_twi_eeprom_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .addr_strap (STRAP),
        .wp         (wp),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model's expectation of a released line
    always @(negedge clk) begin
        if (quiet && rst_n) begin
            n_chk++;
            if (sda_oe !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: sda_oe actual %b expected 0", quiet_req, sda_oe);
            end
        end
    end

    task automatic idle_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; idle_clk(Q);
        scl_m = 1'b1; idle_clk(Q);
        sda_m = 1'b0; idle_clk(Q);
        scl_m = 1'b0; idle_clk(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; idle_clk(Q);
        scl_m = 1'b1; idle_clk(Q);
        sda_m = 1'b1; idle_clk(2 * Q);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b;    idle_clk(Q);
        scl_m = 1'b1; idle_clk(2 * Q);
        scl_m = 1'b0; idle_clk(Q);
    endtask

    task automatic get_bit(output bit b);
        bit b2;
        sda_m = 1'b1; idle_clk(Q);
        scl_m = 1'b1; idle_clk(Q);
        b = sda_line; idle_clk(Q - 1);
        b2 = sda_line;
        check("R11 line stable while SCL high", b2, b);
        idle_clk(1);
        scl_m = 1'b0; idle_clk(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic model_commit(input int raw);
        int a, base, idx;
        a = raw & MASK;
        base = a & ~63;
        idx = a & 63;
        foreach (wdata[i]) begin
            mem_m[base | idx] = wdata[i];
            idx = (idx + 1) & 63;
        end
    endtask

    task automatic write_txn(input int raw, input string req);
        bit ack;
        bus_start;
        put_byte(DEV_W, ack);          check("R1 device ack on write", ack, 1);
        put_byte(8'(raw >> 8), ack);   check("R4 high address ack", ack, 1);
        put_byte(8'(raw), ack);        check("R4 low address ack", ack, 1);
        foreach (wdata[i]) begin
            put_byte(wdata[i], ack);   check(req, ack, 1);
        end
        bus_stop;
        if (!wp) model_commit(raw);
    endtask

    task automatic read_rand(input int raw, input int n, input string req);
        bit ack;
        logic [7:0] v;
        int a;
        a = raw & MASK;
        bus_start;
        put_byte(DEV_W, ack);          check("R1 device ack before read", ack, 1);
        put_byte(8'(raw >> 8), ack);   check("R4 high address ack", ack, 1);
        put_byte(8'(raw), ack);        check("R4 low address ack", ack, 1);
        bus_start;
        put_byte(DEV_R, ack);          check("R1 device ack on read", ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(v, i < n - 1);
            check(req, int'(v), int'(mem_m[(a + i) & MASK]));
        end
        quiet = 1'b1; quiet_req = "R10";
        bus_stop;
        quiet = 1'b0;
    endtask

    task automatic busy_probe;
        bit ack;
        quiet = 1'b1; quiet_req = "R8";
        bus_start;
        put_byte(DEV_W, ack);  check("R8 no ack to write address while busy", ack, 0);
        bus_start;
        put_byte(DEV_R, ack);  check("R8 no ack to read address while busy", ack, 0);
        bus_stop;
        quiet = 1'b0;
    endtask

    task automatic poll_wait;
        bit ack;
        int n;
        ack = 1'b0;
        n = 0;
        while (!ack && n < 100) begin
            bus_start;
            put_byte(DEV_W, ack);
            bus_stop;
            n++;
        end
        check("R8 poll acknowledged after write cycle", ack, 1);
    endtask

    task automatic single_poll(input string req);
        bit ack;
        bus_start;
        put_byte(DEV_W, ack);
        bus_stop;
        check(req, ack, 1);
    endtask

    initial begin
        bit ack;
        idle_clk(10);
        rst_n = 1'b1;
        idle_clk(5);
        check("R3 reset state sda_oe", sda_oe, 0);

        // R3: address byte before power good
        quiet = 1'b1; quiet_req = "R3";
        bus_start;
        put_byte(DEV_W, ack);  check("R3 no ack before power good", ack, 0);
        bus_stop;
        quiet = 1'b0;
        pwr_good = 1'b1;
        idle_clk(5);

        // R2: other strap value
        quiet = 1'b1; quiet_req = "R2";
        bus_start;
        put_byte(8'hA4, ack);  check("R2 no ack on strap mismatch", ack, 0);
        put_byte(8'h00, ack);  check("R2 stays released after mismatch", ack, 0);
        bus_stop;
        quiet = 1'b0;

        // R5/R6: byte write, busy window, poll, read back
        wdata = '{8'hA5};
        write_txn(16'h0000, "R5 data ack");
        busy_probe;
        poll_wait;
        read_rand(16'h0000, 1, "R9 byte write read back");

        // R5: page write wrapping in its page
        wdata = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_txn(16'h007E, "R5 page data ack");
        poll_wait;
        read_rand(16'h007E, 2, "R9 sequential read");
        read_rand(16'h0040, 2, "R5 page wrap stored at page start");

        // R4: bits above ADDR_W ignored
        wdata = '{8'h3C};
        write_txn(16'h7923, "R5 data ack");
        poll_wait;
        read_rand(16'h0123, 1, "R4 upper address bits ignored on write");
        read_rand(16'h4123, 1, "R4 upper address bits ignored on read");

        // R6: stop three bits into the next byte discards
        bus_start;
        put_byte(DEV_W, ack);
        put_byte(8'h01, ack);
        put_byte(8'h23, ack);
        put_byte(8'h99, ack);  check("R6 data ack before late stop", ack, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop;
        single_poll("R6 no write cycle after late stop");
        read_rand(16'h0123, 1, "R6 location unchanged after late stop");

        // R7: write protect
        wp = 1'b1;
        wdata = '{8'h77};
        write_txn(16'h0123, "R7 data ack under protect");
        single_poll("R7 ready at once under protect");
        wp = 1'b0;
        read_rand(16'h0123, 1, "R7 location unchanged under protect");

        // R9: read address wraps past the top
        wdata = '{8'h5A, 8'h6B};
        write_txn(16'h07FF, "R5 data ack at top");
        poll_wait;
        read_rand(16'h07FF, 2, "R9 read wraps to address 0");
        read_rand(16'h07C0, 1, "R5 wrap at top page");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule